// File: doc/BRIEF.md
# Clock-Low Wait Timeout Timer

This block guards an I2C master against a bus clock that stays low for too long, as happens when a target device stretches the clock without end. While the master is waiting on the clock line and that line reads low, the block counts qualified system-clock cycles. A power-of-two prescaler divides them into ticks, and a 15-bit down-counter counts those ticks against a programmed limit. When the limit runs out, the block raises a one-cycle timeout pulse. The transfer sequencer latches that pulse as a timeout status and treats it as a transfer error.

Software programs the block with two values. A 16-bit control word carries the enable flag and the tick limit. A separate 4-bit exponent selects the prescale divide ratio. A typical setup converts a wait limit of about 25 ms into prescaled ticks. It picks the smallest exponent that makes the tick count fit in 15 bits, so the count saturates at 0x7FFF. Any sight of the clock line high, or a cleared enable, restarts the measurement. A soft clear returns the block to its idle state within a single cycle.

All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake.

Top module: `scl_wait_timer`

## Requirements
- R1: After rst_n is deasserted, timeout_o is low. The timer stays idle and cannot expire until it has seen at least one restart cycle, which is a cycle with scl_in high or the enable bit low.
- R2: tmr_ctrl bit 15 is the enable. tmr_ctrl bits 14:0 hold the tick limit N. With pre_exp = p, the timeout_o pulse appears in the cycle after the N*2^p-th qualified rising edge following the last restart, for any p from 0 to 15 and any N up to 0x7FFF.
- R3: A qualified edge is a rising clock edge at which the enable is 1, scl_in is 0 and mst_wait is 1. The prescaler produces one tick every 2^p qualified edges.
- R4: A tick limit of 0 behaves as a limit of 1, so the timeout expires after 2^p qualified edges.
- R5: An edge with scl_in low and mst_wait low pauses the measurement. Progress already made is kept, and counting resumes when mst_wait returns high.
- R6: Any edge with scl_in high and the enable set restarts the measurement, and all progress is lost.
- R7: Any edge with the enable bit low restarts the measurement, and timeout_o never pulses while the block is disabled.
- R8: timeout_o is high for exactly one cycle. After it fires, it stays low until a restart cycle occurs, however long the clock stays low.
- R9: A soft_clr edge clears both counters and a pending pulse in the same cycle. timeout_o is low in the cycle after it, and the timer is idle, as after reset, until the next restart cycle.
- R10: The tick limit is captured at each restart cycle. A change to tmr_ctrl bits 14:0 during a measurement does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous soft clear of counters and pending pulse |
| tmr_ctrl | input | 16 | Bit 15 enable, bits 14:0 tick limit |
| pre_exp | input | 4 | Prescale exponent p; tick every 2^p qualified cycles |
| scl_in | input | 1 | Sampled level of the bus clock line |
| mst_wait | input | 1 | High while the master is waiting on the clock line |
| timeout_o | output | 1 | One-cycle timeout pulse to the transfer sequencer |

## Verification
On every cycle, the assertions check the following: a pulse lasts a single cycle; it follows only an edge that was enabled, had the clock low and had the master waiting; it never follows a soft clear; and at most one pulse occurs between restarts. Only the bench scenarios can show that the pulse lands in exactly the right cycle. Those scenarios cover several prescale exponents, the zero and maximum limits, pauses on mst_wait, and limit changes in the middle of a measurement.

// File: rtl/swt_pkg.sv
package swt_pkg;

  // Default field widths of the timer.
  localparam int unsigned CNT_W_DEF = 15;
  localparam int unsigned EXP_W_DEF = 4;

  // Phase of the tick down-counter.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // disarmed after reset or soft clear
    PH_RUN  = 2'd1,  // armed, counting ticks
    PH_DONE = 2'd2   // expired, holding zero until restart
  } phase_t;

endpackage

// File: rtl/swt_ctrl_decode.sv
module swt_ctrl_decode #(
  parameter int unsigned CNT_W = swt_pkg::CNT_W_DEF,
  parameter int unsigned EXP_W = swt_pkg::EXP_W_DEF,
  localparam int unsigned DIV_W = (1 << EXP_W) - 1
) (
  input  logic [CNT_W:0]   ctrl_word,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             scl_lvl,
  input  logic             waiting,
  output logic             restart,
  output logic             qualified,
  output logic [CNT_W-1:0] limit,
  output logic [DIV_W-1:0] div_mask
);

  logic             enable;
  logic [CNT_W-1:0] raw_limit;

  assign enable    = ctrl_word[CNT_W];
  assign raw_limit = ctrl_word[CNT_W-1:0];

  // A limit of zero is treated as one tick.
  assign limit = (raw_limit == '0) ? CNT_W'(1) : raw_limit;

  assign restart   = !enable || scl_lvl;
  assign qualified = enable && !scl_lvl && waiting;

  // Low exp_sel bits of the mask set: prescale ratio 2^exp_sel.
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign div_mask[i] = (EXP_W'(i) < exp_sel);
  end

endmodule

// File: rtl/swt_prescaler.sv
module swt_prescaler #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             qualified,
  input  logic [DIV_W-1:0] div_mask,
  output logic             tick
);

  logic [DIV_W-1:0] pre_q;

  assign tick = qualified && ((pre_q & div_mask) == div_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr || restart) begin
      pre_q <= '0;
    end else if (qualified) begin
      pre_q <= tick ? '0 : pre_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/swt_downcounter.sv
module swt_downcounter
  import swt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  phase_t           phase_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (clr) begin
        phase_q <= PH_IDLE;
        left_q  <= '0;
      end else if (restart) begin
        phase_q <= PH_RUN;
        left_q  <= limit;
      end else if (tick && phase_q == PH_RUN) begin
        if (left_q == CNT_W'(1)) begin
          left_q  <= '0;
          phase_q <= PH_DONE;
          expire  <= 1'b1;
        end else begin
          left_q <= left_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/scl_wait_timer.sv
module scl_wait_timer #(
  parameter int unsigned CNT_W = swt_pkg::CNT_W_DEF,
  parameter int unsigned EXP_W = swt_pkg::EXP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic [CNT_W:0]   tmr_ctrl,
  input  logic [EXP_W-1:0] pre_exp,
  input  logic             scl_in,
  input  logic             mst_wait,
  output logic             timeout_o
);

  localparam int unsigned DIV_W = (1 << EXP_W) - 1;

  logic             restart;
  logic             qualified;
  logic             tick;
  logic [CNT_W-1:0] limit;
  logic [DIV_W-1:0] div_mask;

  swt_ctrl_decode #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_dec (
    .ctrl_word (tmr_ctrl),
    .exp_sel   (pre_exp),
    .scl_lvl   (scl_in),
    .waiting   (mst_wait),
    .restart   (restart),
    .qualified (qualified),
    .limit     (limit),
    .div_mask  (div_mask)
  );

  swt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .restart   (restart),
    .qualified (qualified),
    .div_mask  (div_mask),
    .tick      (tick)
  );

  swt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .restart (restart),
    .tick    (tick),
    .limit   (limit),
    .expire  (timeout_o)
  );

endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic [CNT_W:0]   tmr_ctrl,
  input logic [EXP_W-1:0] pre_exp,
  input logic             scl_in,
  input logic             mst_wait,
  input logic             timeout_o
);

  logic seen_restart;
  logic fired;
  logic rs_edge;

  assign rs_edge = !tmr_ctrl[CNT_W] || scl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_restart <= 1'b0;
      fired        <= 1'b0;
    end else if (soft_clr) begin
      seen_restart <= 1'b0;
      fired        <= 1'b0;
    end else if (rs_edge) begin
      seen_restart <= 1'b1;
      fired        <= 1'b0;
    end else if (timeout_o) begin
      fired <= 1'b1;
    end
  end

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R8
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !fired);

  // R1
  armed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> seen_restart);

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !timeout_o);

  // R7
  enabled_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_ctrl[CNT_W] |=> !timeout_o);

  // R6
  scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_in |=> !timeout_o);

  // R5
  paused_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_wait |=> !timeout_o);

endmodule

bind scl_wait_timer swt_checker #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_clr  (soft_clr),
  .tmr_ctrl  (tmr_ctrl),
  .pre_exp   (pre_exp),
  .scl_in    (scl_in),
  .mst_wait  (mst_wait),
  .timeout_o (timeout_o)
);

// File: tb/tb_scl_wait_timer.sv
`timescale 1ns/1ps
module tb_scl_wait_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic [15:0] tmr_ctrl = 16'h0000;
  logic [3:0]  pre_exp = 4'd0;
  logic        scl_in = 1'b1;
  logic        mst_wait = 1'b0;
  logic        timeout_o;

  always #2.5 clk = ~clk;

  scl_wait_timer dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .tmr_ctrl(tmr_ctrl),
    .pre_exp(pre_exp), .scl_in(scl_in), .mst_wait(mst_wait),
    .timeout_o(timeout_o)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pulses = 0;
  int last_pulse = 0;
  bit finished = 0;

  // Model state: edges counted since last restart.
  bit m_armed = 0;
  int m_edges = 0;
  int m_limit = 1;
  bit m_exp = 0;

  function automatic int eff_limit(input logic [14:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int fire_point(input int n, input int p);
    return n << p;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    cycles++;
    if (!rst_n) begin
      m_armed = 0; m_edges = 0; m_exp = 0;
    end else begin
      m_exp = 0;
      if (soft_clr) begin
        m_armed = 0; m_edges = 0;
      end else if (!tmr_ctrl[15] || scl_in) begin
        m_armed = 1; m_edges = 0; m_limit = eff_limit(tmr_ctrl[14:0]);
      end else if (mst_wait && m_armed) begin
        m_edges++;
        if (m_edges == fire_point(m_limit, int'(pre_exp))) begin
          m_exp = 1; m_armed = 0;
        end
      end
    end
    #1;
    if (timeout_o) begin pulses++; last_pulse = m_edges; end
    check(tag, int'(timeout_o), int'(m_exp));
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic setup(input logic [14:0] lim, input logic [3:0] p);
    tmr_ctrl = {1'b1, lim}; pre_exp = p; scl_in = 1'b1; mst_wait = 1'b1;
    soft_clr = 1'b0;
    step("R6");
    scl_in = 1'b0;
    pulses = 0;
  endtask

  always @(posedge clk) begin
    if (cycles > 190000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C1A_0042));
    // R1: reset, then clock low without any restart: never fires.
    run("R1", 3);
    rst_n = 1'b1;
    tmr_ctrl = 16'h8001; scl_in = 1'b0; mst_wait = 1'b1;
    pulses = 0;
    run("R1", 20);
    check("R1 no pulse before restart", pulses, 0);

    // R2/R3: p=2, N=3 fires after 12 qualified edges.
    setup(15'd3, 4'd2);
    run("R3", 30);
    check("R3 pulse count", pulses, 1);
    check("R2 pulse position", last_pulse, 12);

    // R4: limit zero behaves as one.
    setup(15'd0, 4'd3);
    run("R4", 20);
    check("R4 pulse count", pulses, 1);
    check("R4 pulse position", last_pulse, 8);

    // R5: pause on mst_wait keeps progress.
    setup(15'd4, 4'd1);
    run("R5", 5);
    mst_wait = 1'b0; run("R5", 10);
    check("R5 no pulse while paused", pulses, 0);
    mst_wait = 1'b1; run("R5", 5);
    check("R5 resumed pulse", pulses, 1);

    // R6: short SCL high restarts.
    setup(15'd5, 4'd0);
    run("R6", 4);
    scl_in = 1'b1; step("R6"); scl_in = 1'b0;
    run("R6", 4);
    check("R6 progress lost", pulses, 0);
    run("R6", 2);
    check("R6 pulse after restart", pulses, 1);

    // R7: disabled never fires.
    setup(15'd2, 4'd0);
    tmr_ctrl[15] = 1'b0;
    run("R7", 30);
    check("R7 disabled no pulse", pulses, 0);

    // R8: long hold after expiry gives one pulse only.
    setup(15'd6, 4'd0);
    run("R8", 200);
    check("R8 single pulse", pulses, 1);

    // R9: soft clear on the expiry edge cancels the pulse and disarms.
    setup(15'd4, 4'd0);
    run("R9", 3);
    soft_clr = 1'b1; step("R9"); soft_clr = 1'b0;
    run("R9", 40);
    check("R9 cleared and idle", pulses, 0);

    // R10: limit change mid-measurement ignored.
    setup(15'd8, 4'd0);
    run("R10", 3);
    tmr_ctrl[14:0] = 15'd2;
    run("R10", 4);
    check("R10 no early pulse", pulses, 0);
    run("R10", 3);
    check("R10 original limit", pulses, 1);
    check("R10 position", last_pulse, 8);

    // R2 boundaries: largest exponent and largest limit.
    setup(15'd1, 4'd15);
    run("R2", 32770);
    check("R2 p=15 pulse", pulses, 1);
    check("R2 p=15 position", last_pulse, 32768);
    setup(15'h7FFF, 4'd0);
    run("R2", 32770);
    check("R2 max limit pulse", pulses, 1);
    check("R2 max limit position", last_pulse, 32767);

    // Constrained random mix, checked every cycle against the model.
    for (int seg = 0; seg < 60; seg++) begin
      tmr_ctrl = {1'b1, 15'($urandom_range(0, 9))};
      pre_exp = 4'($urandom_range(0, 3));
      scl_in = 1'b1; soft_clr = 1'b0;
      step("R3");
      for (int k = 0; k < 64; k++) begin
        scl_in   = ($urandom_range(0, 99) < 12);
        mst_wait = ($urandom_range(0, 99) < 80);
        tmr_ctrl[15] = ($urandom_range(0, 99) < 96);
        soft_clr = ($urandom_range(0, 99) < 2);
        if ($urandom_range(0, 99) < 5) tmr_ctrl[14:0] = 15'($urandom_range(0, 9));
        step("R3");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule